// File: doc/BRIEF.md
# Hint-Driven Branch Redirect Unit

This unit steers instruction fetch in a pipeline that has no dynamic branch predictor. Software issues explicit hint operations, each carrying the address of a future branch and that branch's target. A hint goes into a small table of hinted branches. Each entry then passes through a start-up window of `SETUP_CYC` cycles. After that comes a target-load window of `LOAD_CYC` cycles, during which the target instruction is brought into the hint target buffer. The target memory is modelled as a fixed latency equal to the load window.

When a branch issues, its address is compared with the table. A matching entry that has finished its start-up window counts as recognised. Fetch then continues from the hinted target instead of the in-line fall-through path. One cycle after each branch, the unit reports three things: whether a hint was recognised, the address that fetch was steered to, and the number of stall cycles the branch costs. The stall depends on the hint-to-branch distance `l` and on the branch's real outcome.

With the default configuration (one entry, start-up 8 cycles, load 11 cycles, full resolve penalty 18 cycles), the unit follows the measured penalty curve of a single-slot hint machine. A newer hint for a different branch replaces the older one.

Top module: `hint_branch_fetch`

## Requirements
- R1: After reset, no result is reported and every table entry is invalid. A branch issued before any hint is therefore not recognised.
- R2: A result (`res_valid` high) appears exactly one clock after each cycle in which `br_valid` is high, and in no other cycle.
- R3: A branch that is not recognised steers fetch to `br_pc + 4`. It costs 18 stall cycles if it is taken and 0 if it is not taken.
- R4: A hint issued fewer than 8 cycles before a branch with the same address is not recognised by that branch. Distance 0 means the hint and the branch issue in the same cycle.
- R5: A recognised branch steers fetch to the hinted target. If it is taken at distance 8 ≤ l < 19, the stall is 18 − l.
- R6: A recognised taken branch at distance l ≥ 19 costs 0 stall cycles.
- R7: A recognised branch that is not taken costs 36 − l stall cycles for 8 ≤ l < 19, and 18 for l ≥ 19.
- R8: A branch whose address differs from every hinted address is not recognised.
- R9: With a single entry, a hint for a new address replaces the earlier hint. A branch at the earlier address is then no longer recognised.
- R10: A branch does not consume its hint. A later branch at the same address is recognised once the distance reaches 8, even if an earlier branch at that address was too early to use the hint.
- R11: A new hint for an address that is already in the table replaces that entry's target and restarts its distance from the new hint.
- R12: A branch with `br_uncond` high is treated as taken whatever the value of `br_taken`, and it uses the same lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | A hint issues this cycle |
| hint_pc | input | PC_W | Address of the branch being hinted |
| hint_target | input | PC_W | Target of the hinted branch |
| br_valid | input | 1 | A branch issues this cycle |
| br_pc | input | PC_W | Address of the issuing branch |
| br_taken | input | 1 | Resolved direction of a conditional branch |
| br_uncond | input | 1 | Branch is unconditional (always taken) |
| res_valid | output | 1 | Result for the branch of the previous cycle |
| res_recognised | output | 1 | A hint was recognised for that branch |
| res_fetch_pc | output | PC_W | Address fetch was steered to |
| res_stall | output | SW | Stall cycles charged to that branch |

## Verification
The main pattern sweeps the hint-to-branch distance from 0 to 24 cycles with both branch outcomes. This separates the unrecognised zone, the linear partial-hiding zone and the fully hidden zone, and checks each knee at 8 and 19 from both sides. Further sequences exercise the table's replacement behaviour: an address mismatch, a second hint that overwrites the first, a re-hint of the same address that restarts the distance, and repeated branches on one hint that show the hint is not consumed. The unconditional input is driven with the taken input both low and high, which shows that it forces the taken penalty on both the hinted and the unhinted path.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    // Penalty zone selected for one branch lookup
    typedef enum logic [1:0] {
        ZONE_MISS    = 2'd0,
        ZONE_PARTIAL = 2'd1,
        ZONE_HIDDEN  = 2'd2
    } zone_e;

    // Saturating subtraction a - b, floor at zero
    function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/hbf_btb.sv
module hbf_btb #(
    parameter int ENTRIES   = 1,
    parameter int PC_W      = 16,
    parameter int SETUP_CYC = 8,
    parameter int LOAD_CYC  = 11,
    parameter int AGE_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hint_valid,
    input  logic [PC_W-1:0]  hint_pc,
    input  logic [PC_W-1:0]  hint_target,
    input  logic [PC_W-1:0]  look_pc,
    output logic             look_hit,
    output logic [AGE_W-1:0] look_age,
    output logic [PC_W-1:0]  look_target
);
    localparam int AGE_MAX = SETUP_CYC + LOAD_CYC;
    localparam int VW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  tgt;
        logic [AGE_W-1:0] age;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [VW-1:0]      victim;
    } btb_state_t;

    btb_state_t st_d, st_q;
    logic [ENTRIES-1:0] look_vec;
    logic [ENTRIES-1:0] hint_vec;

    // Per-entry match vectors
    generate
        for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
            assign look_vec[gi] = st_q.ent[gi].valid && (st_q.ent[gi].pc == look_pc)
                                  && (st_q.ent[gi].age >= AGE_W'(SETUP_CYC));
            assign hint_vec[gi] = st_q.ent[gi].valid && (st_q.ent[gi].pc == hint_pc);
        end
    endgenerate

    // Lookup select
    always_comb begin
        look_hit    = 1'b0;
        look_age    = '0;
        look_target = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (look_vec[i]) begin
                look_hit    = 1'b1;
                look_age    = st_q.ent[i].age;
                look_target = st_q.ent[i].tgt;
            end
        end
    end

    // Next state: ageing, hint search and install
    always_comb begin
        logic          hhit;
        logic [VW-1:0] hidx;
        logic [VW-1:0] widx;
        st_d = st_q;
        hhit = 1'b0;
        hidx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].valid && (st_q.ent[i].age < AGE_W'(AGE_MAX)))
                st_d.ent[i].age = st_q.ent[i].age + AGE_W'(1);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hint_vec[i]) begin
                hhit = 1'b1;
                hidx = VW'(i);
            end
        end
        widx = hhit ? hidx : st_q.victim;
        if (hint_valid) begin
            st_d.ent[widx].valid = 1'b1;
            st_d.ent[widx].pc    = hint_pc;
            st_d.ent[widx].tgt   = hint_target;
            st_d.ent[widx].age   = AGE_W'(1);
            if (!hhit)
                st_d.victim = (st_q.victim == VW'(ENTRIES - 1)) ? '0 : st_q.victim + VW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(look_vec));

    generate
        for (genvar ga = 0; ga < ENTRIES; ga++) begin : g_age_chk
            // R6
            age_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.ent[ga].age <= AGE_W'(AGE_MAX));
            // R1
            fresh_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.ent[ga].valid && !$past(st_q.ent[ga].valid) |-> st_q.ent[ga].age == AGE_W'(1));
        end
    endgenerate

endmodule

// File: rtl/hbf_penalty.sv
module hbf_penalty #(
    parameter int SETUP_CYC = 8,
    parameter int LOAD_CYC  = 11,
    parameter int FULL_PEN  = 18,
    parameter int AGE_W     = 5,
    parameter int SW        = 6
) (
    input  logic             hit,
    input  logic [AGE_W-1:0] age,
    input  logic             taken,
    output hbf_pkg::zone_e   zone,
    output logic [SW-1:0]    stall
);
    import hbf_pkg::*;
    localparam int AGE_MAX = SETUP_CYC + LOAD_CYC;

    always_comb begin
        int unsigned remain;
        remain = sat_sub(FULL_PEN, int'(age));
        if (!hit) begin
            zone  = ZONE_MISS;
            stall = taken ? SW'(FULL_PEN) : '0;
        end else begin
            zone = (int'(age) >= AGE_MAX) ? ZONE_HIDDEN : ZONE_PARTIAL;
            if (zone == ZONE_HIDDEN) remain = 0;
            stall = taken ? SW'(remain) : SW'(remain + FULL_PEN);
        end
    end

endmodule

// File: rtl/hint_branch_fetch.sv
module hint_branch_fetch #(
    parameter int PC_W      = 16,
    parameter int ENTRIES   = 1,
    parameter int SETUP_CYC = 8,
    parameter int LOAD_CYC  = 11,
    parameter int FULL_PEN  = 18,
    parameter int INSTR_B   = 4,
    parameter int AGE_W     = $clog2(SETUP_CYC + LOAD_CYC + 1),
    parameter int SW        = $clog2(2 * FULL_PEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hint_valid,
    input  logic [PC_W-1:0] hint_pc,
    input  logic [PC_W-1:0] hint_target,
    input  logic            br_valid,
    input  logic [PC_W-1:0] br_pc,
    input  logic            br_taken,
    input  logic            br_uncond,
    output logic            res_valid,
    output logic            res_recognised,
    output logic [PC_W-1:0] res_fetch_pc,
    output logic [SW-1:0]   res_stall
);
    import hbf_pkg::*;

    typedef struct packed {
        logic            valid;
        logic            recog;
        logic [PC_W-1:0] fpc;
        logic [SW-1:0]   stall;
    } res_state_t;

    res_state_t rs_d, rs_q;

    logic             hit;
    logic [AGE_W-1:0] hit_age;
    logic [PC_W-1:0]  hit_tgt;
    logic             eff_taken;
    zone_e            zone;
    logic [SW-1:0]    stall_c;

    assign eff_taken = br_taken | br_uncond;

    hbf_btb #(
        .ENTRIES(ENTRIES), .PC_W(PC_W), .SETUP_CYC(SETUP_CYC),
        .LOAD_CYC(LOAD_CYC), .AGE_W(AGE_W)
    ) u_btb (
        .clk(clk), .rst_n(rst_n),
        .hint_valid(hint_valid), .hint_pc(hint_pc), .hint_target(hint_target),
        .look_pc(br_pc), .look_hit(hit), .look_age(hit_age), .look_target(hit_tgt)
    );

    hbf_penalty #(
        .SETUP_CYC(SETUP_CYC), .LOAD_CYC(LOAD_CYC), .FULL_PEN(FULL_PEN),
        .AGE_W(AGE_W), .SW(SW)
    ) u_pen (
        .hit(hit), .age(hit_age), .taken(eff_taken), .zone(zone), .stall(stall_c)
    );

    always_comb begin
        rs_d       = '0;
        rs_d.valid = br_valid;
        if (br_valid) begin
            rs_d.recog = (zone != ZONE_MISS);
            rs_d.fpc   = hit ? hit_tgt : br_pc + PC_W'(INSTR_B);
            rs_d.stall = stall_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign res_valid      = rs_q.valid;
    assign res_recognised = rs_q.recog;
    assign res_fetch_pc   = rs_q.fpc;
    assign res_stall      = rs_q.stall;

    // R2
    res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(br_valid));
    // R7
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_stall <= SW'(2 * FULL_PEN));
    // R3
    miss_nt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_recognised && !$past(br_taken || br_uncond) |-> res_stall == '0);
    // R12
    uncond_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(br_uncond) |-> res_stall <= SW'(FULL_PEN));

endmodule

// File: tb/hint_branch_fetch_tb.sv
module hint_branch_fetch_tb;
    localparam int PC_W = 16;
    localparam int SW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hint_valid = 1'b0;
    logic [PC_W-1:0] hint_pc = '0;
    logic [PC_W-1:0] hint_target = '0;
    logic            br_valid = 1'b0;
    logic [PC_W-1:0] br_pc = '0;
    logic            br_taken = 1'b0;
    logic            br_uncond = 1'b0;
    logic            res_valid;
    logic            res_recognised;
    logic [PC_W-1:0] res_fetch_pc;
    logic [SW-1:0]   res_stall;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hint_branch_fetch u_dut (
        .clk(clk), .rst_n(rst_n),
        .hint_valid(hint_valid), .hint_pc(hint_pc), .hint_target(hint_target),
        .br_valid(br_valid), .br_pc(br_pc), .br_taken(br_taken), .br_uncond(br_uncond),
        .res_valid(res_valid), .res_recognised(res_recognised),
        .res_fetch_pc(res_fetch_pc), .res_stall(res_stall)
    );

    function automatic int exp_stall(input int l, input bit taken);
        int part;
        if (l < 8) return taken ? 18 : 0;
        part = (l >= 19) ? 0 : 18 - l;
        return taken ? part : part + 18;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hint(input int pc, input int tgt);
        hint_valid = 1'b1; hint_pc = PC_W'(pc); hint_target = PC_W'(tgt);
        @(negedge clk);
        hint_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic branch(input string tag, input int pc, input bit taken, input bit unc,
                          input bit e_rec, input int e_stall, input int e_pc);
        br_valid = 1'b1; br_pc = PC_W'(pc); br_taken = taken; br_uncond = unc;
        @(negedge clk);
        br_valid = 1'b0; br_taken = 1'b0; br_uncond = 1'b0;
        chk({tag, " R2 valid"}, int'(res_valid), 1);
        chk({tag, " recognised"}, int'(res_recognised), int'(e_rec));
        chk({tag, " stall"}, int'(res_stall), e_stall);
        chk({tag, " fetch_pc"}, int'(res_fetch_pc), e_pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset res_valid", int'(res_valid), 0);
        branch("R1 R3 unhinted taken", 16'h0100, 1'b1, 1'b0, 1'b0, 18, 16'h0104);
        branch("R3 unhinted not-taken", 16'h0110, 1'b0, 1'b0, 1'b0, 0, 16'h0114);
        @(negedge clk);
        chk("R2 idle no result", int'(res_valid), 0);

        // R4 distance 0: hint and branch in the same cycle
        hint_valid = 1'b1; hint_pc = 16'h0180; hint_target = 16'h9000;
        br_valid = 1'b1; br_pc = 16'h0180; br_taken = 1'b1;
        @(negedge clk);
        hint_valid = 1'b0; br_valid = 1'b0; br_taken = 1'b0;
        chk("R4 l=0 recognised", int'(res_recognised), 0);
        chk("R4 l=0 stall", int'(res_stall), 18);

        // Distance sweep: R4 R5 R6 R7
        for (int l = 1; l <= 24; l++) begin
            for (int t = 0; t < 2; t++) begin
                int pc;
                int tgt;
                string tag;
                pc  = 16'h0200 + l * 16 + t * 8;
                tgt = 16'h8000 + l * 4 + t;
                if (l < 8) tag = "R4";
                else if (t == 0) tag = "R7";
                else if (l < 19) tag = "R5";
                else tag = "R6";
                hint(pc, tgt);
                idle(l - 1);
                branch($sformatf("%s sweep l=%0d taken=%0d", tag, l, t), pc, t[0], 1'b0,
                       l >= 8, exp_stall(l, t[0]), (l >= 8) ? tgt : pc + 4);
            end
        end

        // R8 address mismatch
        hint(16'h0400, 16'h7000);
        idle(20);
        branch("R8 mismatch", 16'h0404, 1'b1, 1'b0, 1'b0, 18, 16'h0408);

        // R9 single slot overwrite
        hint(16'h0500, 16'h7100);
        hint(16'h0600, 16'h7200);
        idle(20);
        branch("R9 overwritten hint", 16'h0500, 1'b1, 1'b0, 1'b0, 18, 16'h0504);
        branch("R9 newer hint", 16'h0600, 1'b1, 1'b0, 1'b1, 0, 16'h7200);

        // R10 early branch, then later branches reuse the same hint
        hint(16'h0700, 16'h7300);
        idle(2);
        branch("R10 early l=3", 16'h0700, 1'b1, 1'b0, 1'b0, 18, 16'h0704);
        idle(8);
        branch("R10 later l=12", 16'h0700, 1'b1, 1'b0, 1'b1, 6, 16'h7300);
        branch("R10 again l=13", 16'h0700, 1'b1, 1'b0, 1'b1, 5, 16'h7300);

        // R11 re-hint restarts distance and replaces target
        hint(16'h0800, 16'h7400);
        idle(20);
        hint(16'h0800, 16'h7480);
        idle(9);
        branch("R11 rehint l=10", 16'h0800, 1'b1, 1'b0, 1'b1, 8, 16'h7480);

        // R12 unconditional forces taken
        hint(16'h0900, 16'h7500);
        idle(11);
        branch("R12 hinted uncond l=12", 16'h0900, 1'b0, 1'b1, 1'b1, 6, 16'h7500);
        branch("R12 unhinted uncond", 16'h0A00, 1'b0, 1'b1, 1'b0, 18, 16'h0A04);
        branch("R12 unhinted uncond+taken", 16'h0A10, 1'b1, 1'b1, 1'b0, 18, 16'h0A14);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule